// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads a fixed-length serial configuration word once after power is declared good. It makes a slow mode clock by dividing the master clock. It samples one input bit on each rising edge of that clock, least significant bit first. Once the last bit is in, it publishes a set of decoded operating-mode fields for the rest of the chip:

- the write-back data pattern,
- the core clock multiplier,
- byte order,
- the external write protocol,
- the timer interrupt disable,
- the output drive strength.

A single error flag reports any reserved code, and any bit whose value is fixed by the format but arrives wrong. The mode clock keeps running after the load. Further input is ignored until the next reset.

The stream length and the clock divide ratio are parameters. At their defaults the stream is 256 bits long and the divide ratio is 256. Only the low fifteen bits carry fields. Every later bit must be zero, and the loader folds those bits into one violation flag instead of storing them.

Top module: `boot_mode_loader`

## Requirements
- R1: After reset, `mode_clk`, `cfg_done`, `cfg_err` and every decoded field output are 0.
- R2: `mode_clk` is free-running from reset and keeps running after the load. Its period is DIV master-clock cycles, with DIV/2 cycles high and DIV/2 cycles low.
- R3: Bit 0 is taken on the first master-clock edge that raises `mode_clk` while `pwr_good` is high. Once that has happened, the load continues regardless of `pwr_good`.
- R4: Exactly NBITS bits are taken, one per rising edge of `mode_clk`; bit k is taken on the (k+1)-th such edge. `cfg_done` goes high on the master-clock edge that raises `mode_clk` for bit NBITS-1, and it stays high until reset.
- R5: After `cfg_done`, changes on `mode_din` do not alter any decoded output or `cfg_err`.
- R6: `wb_pattern` equals bits 4:1. Codes 9 to 15 are reserved and set `cfg_err`.
- R7: `clk_mult` equals the 3-bit code in bits 7:5 plus 2, giving 2 to 8. Code 7 is reserved: it gives `clk_mult` = 0 and sets `cfg_err`.
- R8: `big_endian` equals bit 8 (1 means big endian). `tmr_int_dis` equals bit 11 (1 means the timer interrupt on line 5 is disabled).
- R9: `wr_proto` equals bits 10:9. 00 is legacy, 10 is pipelined writes, 11 is write re-issue, and 01 is reserved and sets `cfg_err`.
- R10: `drive_pct` follows bits 14:13: 10 gives 100, 11 gives 83, 00 gives 67 and 01 gives 50.
- R11: `cfg_err` is set if bit 0 is 1, if bit 12 is 0, or if any bit from 15 up to NBITS-1 is 1.
- R12: While `cfg_done` is low, `cfg_err` and all decoded field outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Power-good indication; starts the load |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided serial mode clock |
| cfg_done | output | 1 | All bits loaded; sticky until reset |
| cfg_err | output | 1 | Reserved code or fixed-value bit violated |
| wb_pattern | output | 4 | Write-back data pattern code |
| clk_mult | output | 4 | Core clock multiplier (2 to 8, 0 if reserved) |
| big_endian | output | 1 | Byte order select |
| wr_proto | output | 2 | Write protocol code |
| tmr_int_dis | output | 1 | Timer interrupt disable |
| drive_pct | output | 7 | Output drive strength in percent |

## Verification
A bit counter that slips by one shifts every field. It also moves the `cfg_done` edge away from the rising edge of the 256th mode clock. The bench therefore times `cfg_done` against its own count of mode-clock edges, and it checks each field against a value computed separately for several distinct streams.

A capture path left open after completion would change the fields within one mode-clock period of the input toggling. Stray high bits dropped from the violation flag would leave `cfg_err` low on a stream with bit 200 set. Either fault shows at the ports as soon as the load completes.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
   // field positions inside the serial word (the decoder depends on them)
   localparam int unsigned FIELD_W     = 15;
   localparam int unsigned POS_ZERO0   = 0;
   localparam int unsigned POS_WB_LO   = 1;
   localparam int unsigned POS_MULT_LO = 5;
   localparam int unsigned POS_ENDIAN  = 8;
   localparam int unsigned POS_WP_LO   = 9;
   localparam int unsigned POS_TMR     = 11;
   localparam int unsigned POS_ONE12   = 12;
   localparam int unsigned POS_DRV_LO  = 13;

   localparam logic [3:0] WB_MAX_LEGAL = 4'd8;
   localparam logic [2:0] MULT_RSVD    = 3'd7;

   typedef enum logic [1:0] {
      WP_LEGACY  = 2'b00,
      WP_RSVD    = 2'b01,
      WP_PIPE    = 2'b10,
      WP_REISSUE = 2'b11
   } wr_proto_e;

   typedef struct packed {
      logic [3:0] wb_pattern;
      logic [3:0] clk_mult;
      logic       big_endian;
      logic [1:0] wr_proto;
      logic       tmr_int_dis;
      logic [6:0] drive_pct;
   } mode_fields_t;
endpackage

// File: rtl/boot_clk_div.sv
module boot_clk_div #(
   parameter int unsigned DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   output logic mode_clk,
   output logic rise_stb
);
   localparam int unsigned CW   = $clog2(DIV);
   localparam int unsigned HALF = DIV / 2;
   localparam bit          POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   initial begin
      assert (DIV >= 8 && (DIV % 2) == 0)
         else $error("boot_clk_div: DIV must be even and at least 8");
   end

   // high in the cycle whose closing edge raises mode_clk
   assign rise_stb = (cnt == CW'(HALF - 1));

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
         assign mode_clk = cnt[CW-1];
      end else begin : g_cmp
         logic mclk_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt    <= '0;
               mclk_q <= 1'b0;
            end else begin
               if (cnt == CW'(DIV - 1)) cnt <= '0;
               else                     cnt <= cnt + 1'b1;
               if (rise_stb)                 mclk_q <= 1'b1;
               else if (cnt == CW'(DIV - 1)) mclk_q <= 1'b0;
            end
         end
         assign mode_clk = mclk_q;
      end
   endgenerate

   a_r2_rise_follows_stb : assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> $rose(mode_clk));
endmodule

// File: rtl/boot_shift_seq.sv
module boot_shift_seq #(
   parameter int unsigned NBITS   = 256,
   parameter int unsigned FIELD_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise_stb,
   input  logic               pwr_good,
   input  logic               din,
   output logic [FIELD_W-1:0] low_bits,
   output logic               stray,
   output logic               done
);
   localparam int unsigned CNT_W = $clog2(NBITS + 1);

   logic [CNT_W-1:0] bit_cnt;
   logic             take;

   initial begin
      assert (NBITS > FIELD_W)
         else $error("boot_shift_seq: NBITS must exceed FIELD_W");
   end

   // a load starts with pwr_good and then runs to the end on its own
   assign take = rise_stb && !done && ((bit_cnt != '0) || pwr_good);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         done    <= 1'b0;
         stray   <= 1'b0;
      end else if (take) begin
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == CNT_W'(NBITS - 1)) done <= 1'b1;
         if (bit_cnt >= CNT_W'(FIELD_W) && din) stray <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < FIELD_W; i++) begin : g_cap
         always_ff @(posedge clk) begin
            if (!rst_n)                               low_bits[i] <= 1'b0;
            else if (take && bit_cnt == CNT_W'(i))    low_bits[i] <= din;
         end
      end
   endgenerate

   a_r4_done_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   a_r4_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(NBITS));
   a_r5_frozen_after_done : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(low_bits) && $stable(stray)));
   a_r4_count_moves_on_stb : assert property (@(posedge clk) disable iff (!rst_n)
      !rise_stb |=> $stable(bit_cnt));
endmodule

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
   import boot_mode_pkg::*;
#(
   parameter int unsigned FW = FIELD_W
) (
   input  logic [FW-1:0] low_bits,
   input  logic          stray,
   input  logic          done,
   output mode_fields_t  fields,
   output logic          err
);
   logic [3:0]  wb;
   logic [2:0]  mc;
   wr_proto_e   wp;
   logic [1:0]  drv;
   logic        rsvd_code, fixed_bad;
   logic [6:0]  pct;

   assign wb  = low_bits[POS_WB_LO   +: 4];
   assign mc  = low_bits[POS_MULT_LO +: 3];
   assign wp  = wr_proto_e'(low_bits[POS_WP_LO +: 2]);
   assign drv = low_bits[POS_DRV_LO  +: 2];

   always_comb begin
      unique case (drv)
         2'b10:   pct = 7'd100;
         2'b11:   pct = 7'd83;
         2'b00:   pct = 7'd67;
         default: pct = 7'd50;
      endcase
   end

   assign rsvd_code = (wb > WB_MAX_LEGAL) || (mc == MULT_RSVD) || (wp == WP_RSVD);
   assign fixed_bad = low_bits[POS_ZERO0] || !low_bits[POS_ONE12] || stray;

   always_comb begin
      fields = '0;
      err    = 1'b0;
      if (done) begin
         fields.wb_pattern  = wb;
         fields.clk_mult    = (mc == MULT_RSVD) ? 4'd0 : ({1'b0, mc} + 4'd2);
         fields.big_endian  = low_bits[POS_ENDIAN];
         fields.wr_proto    = wp;
         fields.tmr_int_dis = low_bits[POS_TMR];
         fields.drive_pct   = pct;
         err                = rsvd_code || fixed_bad;
      end
   end
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
   import boot_mode_pkg::*;
#(
   parameter int unsigned DIV   = 256,
   parameter int unsigned NBITS = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       mode_din,
   output logic       mode_clk,
   output logic       cfg_done,
   output logic       cfg_err,
   output logic [3:0] wb_pattern,
   output logic [3:0] clk_mult,
   output logic       big_endian,
   output logic [1:0] wr_proto,
   output logic       tmr_int_dis,
   output logic [6:0] drive_pct
);
   localparam int unsigned PCW = $clog2(DIV) + 1;

   logic               rise_stb;
   logic [FIELD_W-1:0] low_bits;
   logic               stray;
   mode_fields_t       fields;

   boot_clk_div #(.DIV(DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_clk (mode_clk),
      .rise_stb (rise_stb)
   );

   boot_shift_seq #(.NBITS(NBITS), .FIELD_W(FIELD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_stb (rise_stb),
      .pwr_good (pwr_good),
      .din      (mode_din),
      .low_bits (low_bits),
      .stray    (stray),
      .done     (cfg_done)
   );

   boot_mode_decode #(.FW(FIELD_W)) u_dec (
      .low_bits (low_bits),
      .stray    (stray),
      .done     (cfg_done),
      .fields   (fields),
      .err      (cfg_err)
   );

   assign wb_pattern  = fields.wb_pattern;
   assign clk_mult    = fields.clk_mult;
   assign big_endian  = fields.big_endian;
   assign wr_proto    = fields.wr_proto;
   assign tmr_int_dis = fields.tmr_int_dis;
   assign drive_pct   = fields.drive_pct;

   // period watch: counts master cycles between rising edges of mode_clk
   logic [PCW-1:0] per_cnt;
   logic           mclk_d, seen_rise;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_cnt   <= '0;
         mclk_d    <= 1'b0;
         seen_rise <= 1'b0;
      end else begin
         mclk_d <= mode_clk;
         if (mode_clk && !mclk_d) begin
            per_cnt   <= '0;
            seen_rise <= 1'b1;
         end else begin
            per_cnt <= per_cnt + 1'b1;
         end
      end
   end

   a_r2_period : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_clk && !mclk_d && seen_rise) |-> (per_cnt == PCW'(DIV - 1)));
   a_r12_err_needs_done : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> cfg_done);
   a_r7_mult_range : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !cfg_err) |-> (clk_mult >= 4'd2 && clk_mult <= 4'd8));
   a_r10_drive_legal : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> (drive_pct == 7'd100 || drive_pct == 7'd83 ||
                    drive_pct == 7'd67  || drive_pct == 7'd50));
   a_r5_outputs_hold : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> ($stable(wb_pattern) && $stable(clk_mult) && $stable(wr_proto)
                    && $stable(drive_pct) && $stable(cfg_err)));
endmodule

// File: tb/boot_mode_loader_bench.sv
module boot_mode_loader_bench;
   localparam int unsigned DIV   = 16;
   localparam int unsigned NBITS = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b0;
   logic       mode_din = 1'b0;
   logic       mode_clk, cfg_done, cfg_err, big_endian, tmr_int_dis;
   logic [3:0] wb_pattern, clk_mult;
   logic [1:0] wr_proto;
   logic [6:0] drive_pct;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   boot_mode_loader #(.DIV(DIV), .NBITS(NBITS)) u_boot_mode_loader (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_din(mode_din),
      .mode_clk(mode_clk), .cfg_done(cfg_done), .cfg_err(cfg_err),
      .wb_pattern(wb_pattern), .clk_mult(clk_mult), .big_endian(big_endian),
      .wr_proto(wr_proto), .tmr_int_dis(tmr_int_dis), .drive_pct(drive_pct)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NBITS-1:0] mk(input logic [3:0] wb, input logic [2:0] mc,
                                          input logic be, input logic [1:0] wp,
                                          input logic tm, input logic [1:0] dv);
      logic [NBITS-1:0] v = '0;
      v[4:1] = wb; v[7:5] = mc; v[8] = be; v[10:9] = wp;
      v[11] = tm; v[12] = 1'b1; v[14:13] = dv;
      return v;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; pwr_good = 1'b0; mode_din = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
   endtask

   // shift a whole stream; checks cfg_done timing against the 256th rise (R4)
   task automatic load(input logic [NBITS-1:0] v);
      do_reset();
      @(negedge mode_clk);
      mode_din = v[0];
      pwr_good = 1'b1;
      for (int k = 1; k < NBITS; k++) begin
         @(negedge mode_clk);
         if (k == 100) begin
            chk(cfg_done == 1'b0, "R12", "done mid-load", cfg_done, 0);
            chk(cfg_err == 1'b0 && drive_pct == 0 && clk_mult == 0, "R12",
                "fields mid-load", drive_pct, 0);
         end
         if (k == NBITS - 1)
            chk(cfg_done == 1'b0, "R4", "done before last bit", cfg_done, 0);
         mode_din = v[k];
      end
      @(posedge mode_clk);
      #1;
      chk(cfg_done == 1'b1, "R4", "done at last rise", cfg_done, 1);
      @(negedge clk);
   endtask

   task automatic check_outs(input logic [NBITS-1:0] v, input string tag);
      int exp_mult, exp_drv;
      bit exp_err;
      exp_mult = (v[7:5] == 3'd7) ? 0 : int'(v[7:5]) + 2;
      case (v[14:13])
         2'b10: exp_drv = 100;
         2'b11: exp_drv = 83;
         2'b00: exp_drv = 67;
         default: exp_drv = 50;
      endcase
      exp_err = (v[4:1] > 4'd8) || (v[7:5] == 3'd7) || (v[10:9] == 2'b01) ||
                v[0] || !v[12] || (|v[NBITS-1:15]);
      chk(wb_pattern == v[4:1], "R6", {tag, " wb_pattern"}, wb_pattern, v[4:1]);
      chk(clk_mult == exp_mult, "R7", {tag, " clk_mult"}, clk_mult, exp_mult);
      chk(big_endian == v[8] && tmr_int_dis == v[11], "R8", {tag, " endian/timer"},
          {big_endian, tmr_int_dis}, {v[8], v[11]});
      chk(wr_proto == v[10:9], "R9", {tag, " wr_proto"}, wr_proto, v[10:9]);
      chk(drive_pct == exp_drv, "R10", {tag, " drive_pct"}, drive_pct, exp_drv);
      chk(cfg_err == exp_err, "R11", {tag, " cfg_err"}, cfg_err, exp_err);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(mode_clk == 0 && cfg_done == 0 && cfg_err == 0, "R1", "ctrl after reset",
          {mode_clk, cfg_done, cfg_err}, 0);
      chk(wb_pattern == 0 && clk_mult == 0 && wr_proto == 0 && drive_pct == 0 &&
          big_endian == 0 && tmr_int_dis == 0, "R1", "fields after reset", drive_pct, 0);
   endtask

   task automatic t_period();
      realtime t0, t1, t2;
      @(posedge mode_clk); t0 = $realtime;
      @(negedge mode_clk); t1 = $realtime;
      @(posedge mode_clk); t2 = $realtime;
      chk((t2 - t0) == DIV * 20.0, "R2", "mode_clk period ns", int'(t2 - t0), DIV * 20);
      chk((t1 - t0) == DIV * 10.0, "R2", "mode_clk high ns", int'(t1 - t0), DIV * 10);
   endtask

   task automatic t_no_start();
      do_reset();
      repeat (NBITS / 8) @(posedge mode_clk);
      @(negedge clk);
      chk(cfg_done == 1'b0, "R3", "no load without pwr_good", cfg_done, 0);
   endtask

   task automatic t_legal_a();
      logic [NBITS-1:0] v = mk(4'd3, 3'd2, 1'b0, 2'b10, 1'b1, 2'b11);
      load(v);
      check_outs(v, "legal-a");
      t_period();
   endtask

   task automatic t_legal_b();
      logic [NBITS-1:0] v = mk(4'd8, 3'd6, 1'b1, 2'b11, 1'b0, 2'b01);
      load(v);
      check_outs(v, "legal-b");
   endtask

   task automatic t_legal_c();
      logic [NBITS-1:0] v = mk(4'd0, 3'd0, 1'b1, 2'b00, 1'b0, 2'b00);
      load(v);
      check_outs(v, "legal-c");
   endtask

   task automatic t_pwr_drop();
      logic [NBITS-1:0] v = mk(4'd5, 3'd4, 1'b0, 2'b10, 1'b0, 2'b10);
      do_reset();
      @(negedge mode_clk);
      mode_din = v[0];
      pwr_good = 1'b1;
      for (int k = 1; k < NBITS; k++) begin
         @(negedge mode_clk);
         if (k == 3) pwr_good = 1'b0;
         mode_din = v[k];
      end
      @(posedge mode_clk);
      #1;
      chk(cfg_done == 1'b1, "R3", "load continues after pwr_good drop", cfg_done, 1);
      @(negedge clk);
      check_outs(v, "pwr-drop");
   endtask

   task automatic t_ignore_after_done();
      logic [NBITS-1:0] v = mk(4'd7, 3'd1, 1'b1, 2'b10, 1'b1, 2'b10);
      logic [3:0] wb0, cm0;
      logic [6:0] dp0;
      logic e0;
      load(v);
      wb0 = wb_pattern; cm0 = clk_mult; dp0 = drive_pct; e0 = cfg_err;
      for (int k = 0; k < 24; k++) begin
         @(negedge mode_clk);
         mode_din = k[0];
      end
      @(negedge clk);
      chk(wb_pattern == wb0 && clk_mult == cm0 && drive_pct == dp0 && cfg_err == e0,
          "R5", "fields after extra input", {wb_pattern, clk_mult}, {wb0, cm0});
      chk(cfg_done == 1'b1, "R4", "done sticky", cfg_done, 1);
      t_period();
   endtask

   task automatic t_reserved();
      logic [NBITS-1:0] v;
      v = mk(4'd9, 3'd0, 1'b0, 2'b10, 1'b0, 2'b10);  load(v); check_outs(v, "R6 wb=9");
      v = mk(4'd2, 3'd7, 1'b0, 2'b10, 1'b0, 2'b10);  load(v); check_outs(v, "R7 mult=7");
      v = mk(4'd2, 3'd3, 1'b0, 2'b01, 1'b0, 2'b10);  load(v); check_outs(v, "R9 proto=01");
   endtask

   task automatic t_fixed_bits();
      logic [NBITS-1:0] v;
      v = mk(4'd1, 3'd1, 1'b0, 2'b00, 1'b0, 2'b10); v[0] = 1'b1;   load(v); check_outs(v, "R11 bit0");
      v = mk(4'd1, 3'd1, 1'b0, 2'b00, 1'b0, 2'b10); v[12] = 1'b0;  load(v); check_outs(v, "R11 bit12");
      v = mk(4'd1, 3'd1, 1'b0, 2'b00, 1'b0, 2'b10); v[200] = 1'b1; load(v); check_outs(v, "R11 bit200");
   endtask

   initial begin
      t_reset_state();
      t_no_start();
      t_legal_a();
      t_legal_b();
      t_legal_c();
      t_pwr_drop();
      t_ignore_after_done();
      t_reserved();
      t_fixed_bits();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule